// File: doc/BRIEF.md
# DMA FIFO Threshold Request Controller

This block sits beside the data FIFO of one storage-channel DMA path and decides when the bus master should move data. It watches the FIFO occupancy. When the transfer runs from the device toward memory, it raises a write request once the FIFO holds at least a programmed number of eighths of its depth. When the transfer runs from memory toward the device, it raises a read request once at least a programmed number of eighths of the FIFO is free. Both requests are levels. They are only raised while a DMA transfer is active, and they drop as soon as their condition no longer holds.

One 32-bit control word holds the two threshold codes and three controls: a device reset, a device output disable and an interrupt forwarding enable. The same word, when read back, also shows a latched device interrupt flag and two live status bits. Software clears the interrupt flag by writing a one to it. The flag also clears by itself when the device drops its interrupt line. While forwarding is enabled, the flag is driven onto the host interrupt output.

Every output is registered. A value seen on an output reflects the inputs and the control state as they stood at the previous rising clock edge. A register write takes effect at the edge where it is sampled.

Top module: `dma_thresh_ctrl`

## Requirements
- R1: While `rst` is high, and at the first edge after it, `reg_rdata` reads 0, `wr_req`, `rd_req` and `host_irq` are 0, `dev_reset_n` is 1 and `dev_out_dis` is 0.
- R2: The fill code sits in `reg_wdata[30:28]`. The code c selects k eighths, where k = 7 - c for c in 0..6, and code 7 selects k = 1, the same as code 6. `wr_req` is 1 when `fifo_level` >= DEPTH*k/8 and the gating of R4 allows it.
- R3: The drain code sits in `reg_wdata[26:24]`. It uses the same k mapping as R2. `rd_req` is 1 when DEPTH - `fifo_level` >= DEPTH*k/8 and the gating of R4 allows it.
- R4: `wr_req` requires `dma_active`=1 and `dir_to_mem`=1. `rd_req` requires `dma_active`=1 and `dir_to_mem`=0. The two requests are never high together.
- R5: `reg_rdata` returns the fill code in [30:28], the drain code in [26:24], the device reset control in [15], the output disable in [14] and the interrupt enable in [11], as last written.
- R6: Bit 27, bits 23:20, bit 13, bit 12 and every other bit not named in R5, R7 or R11 read as 0, and writing ones to them has no effect.
- R7: The interrupt flag, read at bit 18, sets on a rising edge of `dev_irq`. A write with bit 18 set clears it. When a rising edge and such a write fall on the same edge, the flag sets.
- R8: The interrupt flag reads 0 one edge after `dev_irq` is sampled low, even if no clearing write occurs.
- R9: `host_irq` equals the interrupt flag ANDed with the enable bit 11, delayed by one edge.
- R10: Writing 1 to bit 15 drives `dev_reset_n` to 0, and writing 0 to bit 15 drives it back to 1. Bit 14 drives `dev_out_dis` directly.
- R11: Bit 19 reads 1 when `fifo_level` is nonzero. Bit 16 reads the value of `dma_active`. Writes to either bit have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Registered readback of the control and status word |
| fifo_level | input | $clog2(DEPTH+1) | FIFO occupancy in entries, 0..DEPTH |
| dir_to_mem | input | 1 | 1 = device-to-memory transfer, 0 = memory-to-device transfer |
| dma_active | input | 1 | A DMA transfer is in progress |
| dev_irq | input | 1 | Interrupt line from the device |
| wr_req | output | 1 | Memory-write request level |
| rd_req | output | 1 | Memory-read request level |
| host_irq | output | 1 | Forwarded interrupt to the host |
| dev_reset_n | output | 1 | Device reset, active low |
| dev_out_dis | output | 1 | Disable for the device-side drivers |

## Verification
The interrupt flag has a set path and two clear paths, and these can act on the same edge. The bench drives a rising edge of `dev_irq` in the same cycle as a write with bit 18 set, and expects the flag to read 1. It also clears the flag by a write while the line stays high, and expects the flag to stay at 0. It then drops the line with no write and expects the flag to clear by itself. A behavioural model predicts the flag, the host interrupt and both requests on every clock. The FIFO level sweeps through every threshold code and every occupancy, so each compare boundary is checked on both of its sides.

// File: rtl/dma_thresh_pkg.sv
package dma_thresh_pkg;
  localparam int unsigned WORD_W = 32;

  // control word field positions
  localparam int unsigned FILL_LSB  = 28;
  localparam int unsigned DRAIN_LSB = 24;
  localparam int unsigned NEMPTY_B  = 19;
  localparam int unsigned IRQF_B    = 18;
  localparam int unsigned ACTIVE_B  = 16;
  localparam int unsigned DRST_B    = 15;
  localparam int unsigned ODIS_B    = 14;
  localparam int unsigned IRQEN_B   = 11;

  typedef logic [2:0] thr_code_t;

  typedef struct packed {
    thr_code_t fill_code;
    thr_code_t drain_code;
    logic      dev_rst;
    logic      out_dis;
    logic      irq_en;
  } ctl_t;

  // number of eighths selected by a code; code 7 aliases code 6
  function automatic int unsigned code_eighths(thr_code_t c);
    return (c == 3'd7) ? 1 : (7 - int'(c));
  endfunction

  function automatic logic [31:0] frac_limit(int unsigned depth, thr_code_t c);
    return 32'((depth / 8) * code_eighths(c));
  endfunction
endpackage

// File: rtl/dma_thresh_cmp.sv
module dma_thresh_cmp
  import dma_thresh_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter bit          DRAIN = 1'b0,
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          gate,
  input  thr_code_t     code,
  input  logic [LW-1:0] level,
  output logic          req
);
  logic [31:0] measure;
  logic [31:0] limit;

  generate
    if (DRAIN) begin : g_free
      always_comb measure = 32'(DEPTH) - 32'(level);
    end else begin : g_fill
      always_comb measure = 32'(level);
    end
  endgenerate

  always_comb limit = frac_limit(DEPTH, code);

  always_ff @(posedge clk) begin
    if (rst) req <= 1'b0;
    else     req <= gate && (measure >= limit);
  end
endmodule

// File: rtl/dma_irq_latch.sv
module dma_irq_latch (
  input  logic clk,
  input  logic rst,
  input  logic dev_irq,
  input  logic clr_wr,
  input  logic irq_en,
  output logic flag,
  output logic host_irq
);
  logic line_q;
  logic rise;

  always_comb rise = dev_irq && !line_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q   <= 1'b0;
      flag     <= 1'b0;
      host_irq <= 1'b0;
    end else begin
      line_q   <= dev_irq;
      // a new edge wins over a clearing write; a low line always clears
      flag     <= dev_irq && (rise || (flag && !clr_wr));
      host_irq <= flag && irq_en;
    end
  end
endmodule

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs
  import dma_thresh_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [WORD_W-1:0] reg_wdata,
  input  logic              not_empty,
  input  logic              irq_flag,
  input  logic              dma_active,
  output ctl_t              ctl,
  output logic              dev_reset_n,
  output logic [WORD_W-1:0] reg_rdata
);
  ctl_t              ctl_q;
  logic [WORD_W-1:0] word;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q       <= '0;
      dev_reset_n <= 1'b1;
    end else if (reg_wr) begin
      ctl_q.fill_code  <= reg_wdata[FILL_LSB +: 3];
      ctl_q.drain_code <= reg_wdata[DRAIN_LSB +: 3];
      ctl_q.dev_rst    <= reg_wdata[DRST_B];
      ctl_q.out_dis    <= reg_wdata[ODIS_B];
      ctl_q.irq_en     <= reg_wdata[IRQEN_B];
      dev_reset_n      <= !reg_wdata[DRST_B];
    end
  end

  always_comb begin
    word                    = '0;
    word[FILL_LSB +: 3]     = ctl_q.fill_code;
    word[DRAIN_LSB +: 3]    = ctl_q.drain_code;
    word[NEMPTY_B]          = not_empty;
    word[IRQF_B]            = irq_flag;
    word[ACTIVE_B]          = dma_active;
    word[DRST_B]            = ctl_q.dev_rst;
    word[ODIS_B]            = ctl_q.out_dis;
    word[IRQEN_B]           = ctl_q.irq_en;
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= word;
  end

  assign ctl = ctl_q;
endmodule

// File: rtl/dma_thresh_ctrl.sv
module dma_thresh_ctrl
  import dma_thresh_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic [LW-1:0]     fifo_level,
  input  logic              dir_to_mem,
  input  logic              dma_active,
  input  logic              dev_irq,
  output logic              wr_req,
  output logic              rd_req,
  output logic              host_irq,
  output logic              dev_reset_n,
  output logic              dev_out_dis
);
  ctl_t ctl;
  logic irq_flag;
  logic not_empty;
  logic wr_gate;
  logic rd_gate;

  always_comb begin
    not_empty = (fifo_level != '0);
    wr_gate   = dma_active && dir_to_mem;
    rd_gate   = dma_active && !dir_to_mem;
  end

  dma_ctrl_regs u_regs (
    .clk        (clk),
    .rst        (rst),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata),
    .not_empty  (not_empty),
    .irq_flag   (irq_flag),
    .dma_active (dma_active),
    .ctl        (ctl),
    .dev_reset_n(dev_reset_n),
    .reg_rdata  (reg_rdata)
  );

  assign dev_out_dis = ctl.out_dis;

  dma_irq_latch u_irq (
    .clk     (clk),
    .rst     (rst),
    .dev_irq (dev_irq),
    .clr_wr  (reg_wr && reg_wdata[IRQF_B]),
    .irq_en  (ctl.irq_en),
    .flag    (irq_flag),
    .host_irq(host_irq)
  );

  dma_thresh_cmp #(.DEPTH(DEPTH), .DRAIN(1'b0)) u_fill (
    .clk  (clk),
    .rst  (rst),
    .gate (wr_gate),
    .code (ctl.fill_code),
    .level(fifo_level),
    .req  (wr_req)
  );

  dma_thresh_cmp #(.DEPTH(DEPTH), .DRAIN(1'b1)) u_drain (
    .clk  (clk),
    .rst  (rst),
    .gate (rd_gate),
    .code (ctl.drain_code),
    .level(fifo_level),
    .req  (rd_req)
  );
endmodule

// File: rtl/dma_thresh_chk.sv
module dma_thresh_chk (
  input logic        clk,
  input logic        rst,
  input logic        reg_wr,
  input logic [31:0] reg_wdata,
  input logic        dir_to_mem,
  input logic        dma_active,
  input logic        dev_irq,
  input logic        wr_req,
  input logic        rd_req,
  input logic        host_irq,
  input logic        dev_reset_n,
  input logic        irq_flag
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!wr_req && !rd_req && !host_irq && dev_reset_n));

  // R4
  req_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_req && rd_req));

  // R4
  wr_gate_chk: assert property (@(posedge clk) disable iff (rst)
    wr_req |-> ($past(dma_active) && $past(dir_to_mem)));

  // R4
  rd_gate_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> ($past(dma_active) && !$past(dir_to_mem)));

  // R7
  irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (dev_irq && !$past(dev_irq)) |=> irq_flag);

  // R8
  irq_auto_clr_chk: assert property (@(posedge clk) disable iff (rst)
    !dev_irq |=> !irq_flag);

  // R9
  host_irq_src_chk: assert property (@(posedge clk) disable iff (rst)
    host_irq |-> $past(irq_flag));

  // R10
  dev_rst_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_wdata[15]) |=> !dev_reset_n);
endmodule

bind dma_thresh_ctrl dma_thresh_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .reg_wr     (reg_wr),
  .reg_wdata  (reg_wdata),
  .dir_to_mem (dir_to_mem),
  .dma_active (dma_active),
  .dev_irq    (dev_irq),
  .wr_req     (wr_req),
  .rd_req     (rd_req),
  .host_irq   (host_irq),
  .dev_reset_n(dev_reset_n),
  .irq_flag   (irq_flag)
);

// File: tb/dma_thresh_ctrl_tb.sv
`timescale 1ns/1ps
module dma_thresh_ctrl_tb;
  localparam int DEPTH = 64;
  localparam int LW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_wr = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [LW-1:0] fifo_level = '0;
  logic          dir_to_mem = 1'b0;
  logic          dma_active = 1'b0;
  logic          dev_irq = 1'b0;
  logic          wr_req, rd_req, host_irq, dev_reset_n, dev_out_dis;

  int tests = 0;
  int fails = 0;
  bit chk_on = 1'b0;

  always #2 clk = ~clk;

  dma_thresh_ctrl #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .fifo_level(fifo_level), .dir_to_mem(dir_to_mem),
    .dma_active(dma_active), .dev_irq(dev_irq), .wr_req(wr_req),
    .rd_req(rd_req), .host_irq(host_irq), .dev_reset_n(dev_reset_n),
    .dev_out_dis(dev_out_dis)
  );

  // ---------------- reference model ----------------
  int m_fill, m_drain, m_rst, m_dis, m_en, m_flag, m_line;
  logic [31:0] e_rdata;
  logic e_wr, e_rd, e_host, e_rstn, e_dis;

  function automatic int eighths(int c);
    if (c == 7) return 1;
    return 7 - c;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_fill = 0; m_drain = 0; m_rst = 0; m_dis = 0; m_en = 0;
      m_flag = 0; m_line = 0;
      e_rdata = 0; e_wr = 0; e_rd = 0; e_host = 0; e_rstn = 1; e_dis = 0;
    end else begin
      int lvl;
      int nflag;
      lvl = int'(fifo_level);
      e_rdata = 0;
      e_rdata[30:28] = 3'(m_fill);
      e_rdata[26:24] = 3'(m_drain);
      e_rdata[19] = (lvl != 0);
      e_rdata[18] = m_flag[0];
      e_rdata[16] = dma_active;
      e_rdata[15] = m_rst[0];
      e_rdata[14] = m_dis[0];
      e_rdata[11] = m_en[0];
      e_wr = dma_active && dir_to_mem && (lvl >= (DEPTH / 8) * eighths(m_fill));
      e_rd = dma_active && !dir_to_mem && ((DEPTH - lvl) >= (DEPTH / 8) * eighths(m_drain));
      e_host = (m_flag != 0) && (m_en != 0);
      if (!dev_irq) nflag = 0;
      else if (m_line == 0) nflag = 1;
      else if (reg_wr && reg_wdata[18]) nflag = 0;
      else nflag = m_flag;
      m_flag = nflag;
      m_line = dev_irq;
      if (reg_wr) begin
        m_fill = int'(reg_wdata[30:28]);
        m_drain = int'(reg_wdata[26:24]);
        m_rst = reg_wdata[15];
        m_dis = reg_wdata[14];
        m_en = reg_wdata[11];
      end
      e_rstn = (m_rst == 0);
      e_dis = m_dis[0];
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      check("R2/R4 wr_req", 32'(wr_req), 32'(e_wr));
      check("R3/R4 rd_req", 32'(rd_req), 32'(e_rd));
      check("R9 host_irq", 32'(host_irq), 32'(e_host));
      check("R10 dev_reset_n", 32'(dev_reset_n), 32'(e_rstn));
      check("R10 dev_out_dis", 32'(dev_out_dis), 32'(e_dis));
      check("R5/R6/R7/R8/R11 reg_rdata", reg_rdata, e_rdata);
    end
  end

  // ---------------- stimulus ----------------
  logic [31:0] ctl_word = '0;

  task automatic tick(int n = 1);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic wr_ctl(logic [31:0] v);
    reg_wr = 1'b1;
    reg_wdata = v;
    tick();
    reg_wr = 1'b0;
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tick(3);
    @(negedge clk);
    // R1 reset state
    check("R1 rdata", reg_rdata, 32'h0);
    check("R1 reqs", {30'b0, wr_req, rd_req}, 32'h0);
    check("R1 dev_reset_n", 32'(dev_reset_n), 32'h1);
    check("R1 dev_out_dis", 32'(dev_out_dis), 32'h0);
    @(posedge clk); #1;
    rst = 1'b0;
    tick();
    @(negedge clk);
    check("R1 first edge rdata", reg_rdata, 32'h0);
    chk_on = 1'b1;
    tick();

    // R2 fill threshold sweep, all codes
    dma_active = 1'b1;
    dir_to_mem = 1'b1;
    for (int c = 0; c < 8; c++) begin
      ctl_word = {1'b0, 3'(c), 28'h0};
      wr_ctl(ctl_word);
      for (int l = 0; l <= DEPTH; l++) begin
        fifo_level = LW'(l);
        tick();
      end
    end
    // R3 drain threshold sweep, all codes
    dir_to_mem = 1'b0;
    for (int c = 0; c < 8; c++) begin
      ctl_word = {5'b0, 3'(c), 24'h0};
      wr_ctl(ctl_word);
      for (int l = DEPTH; l >= 0; l--) begin
        fifo_level = LW'(l);
        tick();
      end
    end
    // R4 gating: no DMA, either direction
    dma_active = 1'b0;
    for (int l = 0; l <= DEPTH; l += 8) begin
      fifo_level = LW'(l);
      dir_to_mem = l[3];
      tick();
    end
    @(negedge clk);
    check("R4 idle wr_req", 32'(wr_req), 32'h0);
    check("R4 idle rd_req", 32'(rd_req), 32'h0);

    // R6/R11 reserved and read-only bits ignore writes
    fifo_level = '0;
    tick();
    wr_ctl(32'hFFFF_FFFF);
    wr_ctl(32'hFFFF_FFFF);
    tick();
    @(negedge clk);
    check("R6 reserved bits", reg_rdata & ~32'h7704_C800, 32'h0);
    check("R11 status bits idle", {30'b0, reg_rdata[19], reg_rdata[16]}, 32'h0);
    ctl_word = 32'h0000_0800;  // interrupt forwarding on
    wr_ctl(ctl_word);
    tick(2);

    // R7 set on rising edge, then write-one clear while line held
    dev_irq = 1'b1;
    tick(3);
    @(negedge clk);
    check("R7 flag set", 32'(reg_rdata[18]), 32'h1);
    check("R9 host_irq", 32'(host_irq), 32'h1);
    tick();
    wr_ctl(ctl_word | 32'h0004_0000);
    tick(2);
    @(negedge clk);
    check("R7 write clear", 32'(reg_rdata[18]), 32'h0);
    tick();
    // R8 auto clear on line drop
    dev_irq = 1'b0;
    tick();
    dev_irq = 1'b1;
    tick(2);
    dev_irq = 1'b0;
    tick(2);
    @(negedge clk);
    check("R8 auto clear", 32'(reg_rdata[18]), 32'h0);
    tick();
    // R7 collision: rising edge together with clearing write
    dev_irq = 1'b1;
    wr_ctl(ctl_word | 32'h0004_0000);
    tick();
    @(negedge clk);
    check("R7 collision set wins", 32'(reg_rdata[18]), 32'h1);
    tick();
    // R9 forwarding disabled
    ctl_word = 32'h0;
    wr_ctl(ctl_word);
    tick(2);
    @(negedge clk);
    check("R9 forwarding off", 32'(host_irq), 32'h0);
    tick();
    dev_irq = 1'b0;

    // R10 device controls
    wr_ctl(32'h0000_8000);
    tick();
    @(negedge clk);
    check("R10 reset low", 32'(dev_reset_n), 32'h0);
    tick();
    wr_ctl(32'h0000_4000);
    tick();
    @(negedge clk);
    check("R10 reset released", 32'(dev_reset_n), 32'h1);
    check("R10 outputs disabled", 32'(dev_out_dis), 32'h1);
    tick();
    // R11 status visible
    dma_active = 1'b1;
    fifo_level = LW'(5);
    tick(2);
    @(negedge clk);
    check("R11 status bits", {30'b0, reg_rdata[19], reg_rdata[16]}, 32'h3);
    tick(2);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule